// File: doc/BRIEF.md
# Banked Memory Mapper with ROM Overlay

This block sits between a CPU's 16-bit memory port and three memories: a 64 KiB RAM and two 16 KiB ROMs. The address space is cut into four 16 KiB banks. The two top address bits choose the bank and the rest give the offset inside it. A low ROM can shadow bank 0 and a high ROM can shadow bank 3, but only for reads. Writes always land in RAM at the full address, so software can fill the RAM that sits under a ROM and see it later by switching the overlay off. Instruction fetches use the same path as data reads.

Requests enter on a valid/ready stream. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. In the cycle of acceptance the mapper drives exactly one memory strobe, with its address, combinationally from the request. Each memory is synchronous and returns data one cycle after its read strobe. It must hold that data until its next read strobe. Read results leave on a second valid/ready stream. The response stage holds one entry. While a response is pending and `rsp_ready` is low, `req_ready` is low and no new request is accepted. A write produces no response.

A one-cycle strobe, `ctrl_wr`, loads the two overlay enables from a control byte. Both overlays are enabled out of reset.

Top module: `bank_mapper`

## Requirements
- R1: The bank is `req_addr[15:14]` and the offset is `req_addr[13:0]`. `ram_addr` equals the full `req_addr`, and `lo_rom_addr` and `hi_rom_addr` equal the offset.
- R2: A read of bank 0 strobes `lo_rom_re` and returns low ROM data while the low overlay is enabled. Otherwise it strobes `ram_re` and returns RAM data.
- R3: A read of bank 3 strobes `hi_rom_re` and returns high ROM data while the high overlay is enabled. Otherwise it strobes `ram_re` and returns RAM data.
- R4: Reads of banks 1 and 2 always strobe `ram_re` and return RAM data.
- R5: A write strobes `ram_we` with `ram_addr` equal to `req_addr` and `ram_wdata` equal to `req_wdata`, whatever the overlay state. It strobes no ROM and produces no response.
- R6: After reset both overlays are enabled. `rsp_valid` is low and `req_ready` is high.
- R7: On `ctrl_wr`, control bit 2 set disables the low overlay and clear enables it. Control bit 3 does the same for the high overlay. The other bits have no effect, and without `ctrl_wr` the enables do not change. A request accepted in the same cycle as `ctrl_wr` still uses the old enables.
- R8: `rsp_valid` rises in the cycle after a read is accepted. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold and `req_ready` is low.
- R9: At most one of `ram_re`, `ram_we`, `lo_rom_re` and `hi_rom_re` is high in any cycle, and none is high unless a request is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Mapper can accept a request |
| req_addr | input | 16 | CPU address |
| req_we | input | 1 | 1 = write, 0 = read or fetch |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | 8 | Read data |
| ctrl_wr | input | 1 | Control byte write strobe |
| ctrl_data | input | 8 | Control byte (bit 2 low off, bit 3 high off) |
| ram_addr | output | 16 | RAM address |
| ram_re | output | 1 | RAM read strobe |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after ram_re |
| lo_rom_addr | output | 14 | Low ROM offset |
| lo_rom_re | output | 1 | Low ROM read strobe |
| lo_rom_rdata | input | 8 | Low ROM data, one cycle after lo_rom_re |
| hi_rom_addr | output | 14 | High ROM offset |
| hi_rom_re | output | 1 | High ROM read strobe |
| hi_rom_rdata | input | 8 | High ROM data, one cycle after hi_rom_re |

## Verification
A wrong overlay enable has no status pin. It shows up as a wrong memory strobe in the very cycle the next bank 0 or bank 3 read is accepted, and as wrong data one cycle later. A wrong recorded read source does not change any strobe. It shows only in `rsp_data`, in the cycle after the read is accepted. A write sent to the wrong RAM address stays hidden until the bench reads that location back, which is why writes under an active overlay are later read again with the overlay off. A response flag stuck high or low shows up at once as a blocked `req_ready` or a missing `rsp_valid`.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
  // which memory answers a read that was accepted one cycle earlier
  typedef enum logic [1:0] {
    SRC_RAM      = 2'd0,
    SRC_LOW_ROM  = 2'd1,
    SRC_HIGH_ROM = 2'd2
  } rd_src_e;
endpackage

// File: rtl/overlay_ctrl.sv
module overlay_ctrl #(
  parameter int CTRL_W     = 8,
  parameter int LO_DIS_BIT = 2,
  parameter int HI_DIS_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_data,
  output logic              lo_en,
  output logic              hi_en
);
  // both overlays start enabled; a control write sets each from its disable bit
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_en <= 1'b1;
      hi_en <= 1'b1;
    end else if (ctrl_wr) begin
      lo_en <= ~ctrl_data[LO_DIS_BIT];
      hi_en <= ~ctrl_data[HI_DIS_BIT];
    end
  end

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> ($stable(lo_en) && $stable(hi_en))); // R7
endmodule

// File: rtl/bank_decode.sv
module bank_decode
  import bank_mapper_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 2,
  localparam int OFF_W = ADDR_W - BANK_W
) (
  input  logic              fire,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic              lo_en,
  input  logic              hi_en,
  output logic              ram_re,
  output logic              ram_we,
  output logic              lo_re,
  output logic              hi_re,
  output logic [OFF_W-1:0]  offset,
  output rd_src_e           src
);
  logic [BANK_W-1:0] bank;
  logic              rd;
  logic              lo_hit, hi_hit;

  assign bank   = addr[ADDR_W-1 -: BANK_W];
  assign offset = addr[OFF_W-1:0];
  assign rd     = fire && !we;

  // the lowest and the highest bank can be shadowed by a ROM
  assign lo_hit = (bank == '0) && lo_en;
  assign hi_hit = (bank == {BANK_W{1'b1}}) && hi_en;

  always_comb begin
    if (lo_hit)      src = SRC_LOW_ROM;
    else if (hi_hit) src = SRC_HIGH_ROM;
    else             src = SRC_RAM;
  end

  assign lo_re  = rd && (src == SRC_LOW_ROM);
  assign hi_re  = rd && (src == SRC_HIGH_ROM);
  assign ram_re = rd && (src == SRC_RAM);
  assign ram_we = fire && we;
endmodule

// File: rtl/rsp_stage.sv
module rsp_stage
  import bank_mapper_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  rd_src_e           src_in,
  input  logic              rsp_ready,
  input  logic [DATA_W-1:0] ram_q,
  input  logic [DATA_W-1:0] lo_q,
  input  logic [DATA_W-1:0] hi_q,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              can_accept
);
  rd_src_e src_q;

  // one-entry slot; a new read may enter in the same cycle the old one leaves
  assign can_accept = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      src_q     <= SRC_RAM;
    end else begin
      if (load) begin
        rsp_valid <= 1'b1;
        src_q     <= src_in;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // memories hold their output until their next read strobe, and none is
  // strobed while the slot is stalled, so a plain mux is stable during a stall
  always_comb begin
    case (src_q)
      SRC_LOW_ROM:  rsp_data = lo_q;
      SRC_HIGH_ROM: rsp_data = hi_q;
      default:      rsp_data = ram_q;
    endcase
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(src_q))); // R8
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_mapper_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int BANK_W     = 2,
  parameter int DATA_W     = 8,
  parameter int CTRL_W     = 8,
  parameter int LO_DIS_BIT = 2,
  parameter int HI_DIS_BIT = 3,
  localparam int OFF_W     = ADDR_W - BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_data,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_re,
  output logic              ram_we,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [OFF_W-1:0]  lo_rom_addr,
  output logic              lo_rom_re,
  input  logic [DATA_W-1:0] lo_rom_rdata,
  output logic [OFF_W-1:0]  hi_rom_addr,
  output logic              hi_rom_re,
  input  logic [DATA_W-1:0] hi_rom_rdata
);
  logic            fire;
  logic            lo_en, hi_en;
  logic [OFF_W-1:0] offset;
  rd_src_e         src;

  assign fire = req_valid && req_ready;

  overlay_ctrl #(
    .CTRL_W(CTRL_W), .LO_DIS_BIT(LO_DIS_BIT), .HI_DIS_BIT(HI_DIS_BIT)
  ) u_ovl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
    .lo_en(lo_en), .hi_en(hi_en)
  );

  bank_decode #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_dec (
    .fire(fire), .we(req_we), .addr(req_addr), .lo_en(lo_en), .hi_en(hi_en),
    .ram_re(ram_re), .ram_we(ram_we), .lo_re(lo_rom_re), .hi_re(hi_rom_re),
    .offset(offset), .src(src)
  );

  rsp_stage #(.DATA_W(DATA_W)) u_rsp (
    .clk(clk), .rst_n(rst_n), .load(fire && !req_we), .src_in(src),
    .rsp_ready(rsp_ready), .ram_q(ram_rdata), .lo_q(lo_rom_rdata),
    .hi_q(hi_rom_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .can_accept(req_ready)
  );

  assign ram_addr    = req_addr;
  assign ram_wdata   = req_wdata;
  assign lo_rom_addr = offset;
  assign hi_rom_addr = offset;

  logic [BANK_W-1:0] bank_chk;
  assign bank_chk = req_addr[ADDR_W-1 -: BANK_W];

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ram_re, ram_we, lo_rom_re, hi_rom_re}) <= 1); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |-> !(ram_re || ram_we || lo_rom_re || hi_rom_re)); // R9
  AST_WRITE_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_we) |-> (ram_we && !lo_rom_re && !hi_rom_re)); // R5
  AST_MID_BANK_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_we && bank_chk != '0 && bank_chk != {BANK_W{1'b1}})
      |-> ram_re); // R4
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_we) |=> rsp_valid); // R8
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready); // R8
endmodule

// File: tb/tb_bank_mapper.sv
`timescale 1ns/1ps
module tb_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0, rsp_ready = 1'b0, ctrl_wr = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, ctrl_data = '0;
  logic        req_ready, rsp_valid, ram_re, ram_we, lo_rom_re, hi_rom_re;
  logic [7:0]  rsp_data, ram_wdata, ram_q, lo_q, hi_q;
  logic [15:0] ram_addr;
  logic [13:0] lo_rom_addr, hi_rom_addr;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bank_mapper dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data), .ram_addr(ram_addr),
    .ram_re(ram_re), .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_q),
    .lo_rom_addr(lo_rom_addr), .lo_rom_re(lo_rom_re), .lo_rom_rdata(lo_q),
    .hi_rom_addr(hi_rom_addr), .hi_rom_re(hi_rom_re), .hi_rom_rdata(hi_q)
  );

  function automatic logic [7:0] ram_init(logic [15:0] a);
    return (a[7:0] + 8'(a[15:8] * 3)) ^ 8'h96;
  endfunction
  function automatic logic [7:0] lo_rom_f(logic [13:0] o);
    return o[7:0] ^ {2'b00, o[13:8]} ^ 8'h5A;
  endfunction
  function automatic logic [7:0] hi_rom_f(logic [13:0] o);
    return {o[3:0], o[7:4]} ^ {o[13:8], 2'b11} ^ 8'hC3;
  endfunction

  // environment memories, driven only by the DUT's strobes
  logic [7:0] env_ram [int];
  always @(posedge clk) begin
    if (ram_we) env_ram[int'(ram_addr)] = ram_wdata;
    if (ram_re) ram_q <= env_ram.exists(int'(ram_addr)) ? env_ram[int'(ram_addr)] : ram_init(ram_addr);
    if (lo_rom_re) lo_q <= lo_rom_f(lo_rom_addr);
    if (hi_rom_re) hi_q <= hi_rom_f(hi_rom_addr);
  end

  // reference model
  logic [7:0] ref_ram [int];
  bit ref_lo = 1, ref_hi = 1;

  function automatic int exp_src(logic [15:0] a);
    if (a[15:14] == 2'd0 && ref_lo) return 1;
    if (a[15:14] == 2'd3 && ref_hi) return 2;
    return 0;
  endfunction
  function automatic logic [7:0] exp_data(logic [15:0] a);
    case (exp_src(a))
      1: return lo_rom_f(a[13:0]);
      2: return hi_rom_f(a[13:0]);
      default: return ref_ram.exists(int'(a)) ? ref_ram[int'(a)] : ram_init(a);
    endcase
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic string bank_req(logic [15:0] a);
    case (a[15:14])
      2'd0: return "R2";
      2'd3: return "R3";
      default: return "R4";
    endcase
  endfunction

  // read with optional same-cycle control write and a stall of `stall` cycles
  task automatic do_read(logic [15:0] a, int stall, bit with_ctrl = 0, logic [7:0] cv = 0);
    int s = exp_src(a);
    logic [7:0] e = exp_data(a);
    string rq = bank_req(a);
    @(negedge clk);
    chk("R8 req_ready before read", req_ready, 1);
    req_valid = 1; req_we = 0; req_addr = a; rsp_ready = 0;
    ctrl_wr = with_ctrl; ctrl_data = cv;
    #1;
    chk({rq, " lo strobe"}, lo_rom_re, s == 1);
    chk({rq, " hi strobe"}, hi_rom_re, s == 2);
    chk({rq, " ram strobe"}, ram_re, s == 0);
    chk("R9 no write on read", ram_we, 0);
    if (s == 0) chk("R1 ram_addr", ram_addr, a);
    if (s == 1) chk("R1 lo_rom_addr", lo_rom_addr, a[13:0]);
    if (s == 2) chk("R1 hi_rom_addr", hi_rom_addr, a[13:0]);
    if (with_ctrl) begin ref_lo = !cv[2]; ref_hi = !cv[3]; end
    @(negedge clk);
    req_valid = 0; ctrl_wr = 0;
    chk("R8 rsp_valid after read", rsp_valid, 1);
    chk({rq, " rsp_data"}, rsp_data, e);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk("R8 stall valid", rsp_valid, 1);
      chk("R8 stall data", rsp_data, e);
      chk("R8 stall ready", req_ready, 0);
      chk("R9 stall quiet", {ram_re, lo_rom_re, hi_rom_re, ram_we}, 0);
    end
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    chk("R8 rsp drained", rsp_valid, 0);
  endtask

  task automatic do_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_we = 1; req_addr = a; req_wdata = d;
    #1;
    chk("R5 ram_we", ram_we, 1);
    chk("R5 ram_addr", ram_addr, a);
    chk("R5 ram_wdata", ram_wdata, d);
    chk("R5 no rom strobe", {lo_rom_re, hi_rom_re, ram_re}, 0);
    ref_ram[int'(a)] = d;
    @(negedge clk);
    req_valid = 0; req_we = 0;
    chk("R5 no response", rsp_valid, 0);
  endtask

  task automatic do_ctrl(logic [7:0] cv);
    @(negedge clk);
    ctrl_wr = 1; ctrl_data = cv;
    @(negedge clk);
    ctrl_wr = 0;
    ref_lo = !cv[2]; ref_hi = !cv[3];
  endtask

  initial begin
    void'($urandom(32'd7351));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R6 rsp_valid reset", rsp_valid, 0);
    chk("R6 req_ready reset", req_ready, 1);
    // R6: overlays on after reset
    do_read(16'h0123, 0);
    do_read(16'hC456, 0);
    // R5: writes under active overlays reach RAM
    do_write(16'h0123, 8'hA1);
    do_write(16'hC456, 8'hB2);
    do_write(16'h3FFF, 8'h11);
    do_write(16'hC000, 8'h22);
    do_read(16'h0123, 1);           // still ROM
    do_read(16'h3FFF, 0);           // R1 boundary
    do_read(16'hC000, 0);
    do_read(16'h4000, 0);           // R4
    do_read(16'hBFFF, 2);
    // R7: low off only
    do_ctrl(8'h04);
    do_read(16'h0123, 0);
    do_read(16'hC456, 0);
    // R7: both off
    do_ctrl(8'h0C);
    do_read(16'h3FFF, 0);
    do_read(16'hC000, 3);
    // R7: other bits ignored, both back on
    do_ctrl(8'hF3);
    do_read(16'h0123, 0);
    do_read(16'hC456, 0);
    // R7: same-cycle control write uses old state, next read new state
    do_read(16'h0123, 0, 1, 8'h0C);
    do_read(16'h0123, 0);
    do_read(16'hC456, 0, 1, 8'h00);
    do_read(16'hC456, 0);
    // random mix
    for (int n = 0; n < 400; n++) begin
      int k = $urandom_range(0, 9);
      logic [15:0] a = 16'($urandom);
      if (n % 3 == 0) a[13:0] = 14'($urandom_range(0, 15));
      if (k < 3) do_write(a, 8'($urandom));
      else if (k == 3) do_ctrl(8'($urandom));
      else do_read(a, $urandom_range(0, 3), k == 4, 8'($urandom));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule